// File: doc/BRIEF.md
# Four-Accumulator Integer Multiply-Accumulate Unit

This block multiplies two 32-bit integers and folds the 64-bit product into one of four 64-bit accumulators. Each accumulator is a pair of 32-bit halves, an upper word (HI) and a lower word (LO). The pair is chosen by a 2-bit field taken from the instruction word. A separate 2-bit operation code picks one of four operations. The product can be added to the pair, subtracted from it, or written over it. The operands are read as signed or as unsigned, depending on the operation.

An operation is requested by raising `valid_i` for one cycle, and it finishes on that same clock edge. An enable input for the signal-processing extension is checked before anything else happens. While it is low, a request changes no accumulator and produces a one-cycle fault pulse instead. A combinational read port returns HI and LO of any accumulator, so that the host or a bench can inspect the state.

Top module: `mac_quad_acc`

## Requirements
- R1: The accumulator written by an operation is the one whose index is given by `instr_i[15:14]` (0 to 3). All other instruction bits are ignored.
- R2: Op code 0 (unsigned multiply-add): both operands are zero-extended and multiplied, and the product is added to {HI,LO}.
- R3: Op code 1 (unsigned multiply): the 64-bit zero-extended product replaces {HI,LO}, so the earlier contents are lost.
- R4: Op code 2 (signed multiply-subtract): both operands are sign-extended and multiplied, and the product is subtracted from {HI,LO}.
- R5: Op code 3 (unsigned multiply-subtract): both operands are zero-extended and multiplied, and the product is subtracted from {HI,LO}.
- R6: Addition and subtraction wrap modulo 2^64, with no saturation. After every write, the upper 32 bits of the result are in HI and the lower 32 bits are in LO.
- R7: When `valid_i` is high and `dsp_en_i` is low, no accumulator changes.
- R8: `fault_o` is high for exactly the one cycle that follows each edge at which `valid_i` is high and `dsp_en_i` is low. At every other time it is low.
- R9: Synchronous reset clears all four accumulators to zero and clears `fault_o`.
- R10: An operation leaves the three unselected accumulators unchanged. A cycle with `valid_i` low changes nothing.
- R11: `rd_hi_o` and `rd_lo_o` show, combinationally, HI and LO of the accumulator indexed by `rd_sel_i`. A result can be read there right after the edge that wrote it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| valid_i | input | 1 | Operation request strobe |
| dsp_en_i | input | 1 | Signal-processing extension enable |
| op_i | input | 2 | Operation code (0 maddu, 1 multu, 2 msub, 3 msubu) |
| instr_i | input | 32 | Instruction word; bits 15:14 select the accumulator |
| opa_i | input | 32 | First operand |
| opb_i | input | 32 | Second operand |
| rd_sel_i | input | 2 | Accumulator index for the read port |
| rd_hi_o | output | 32 | HI of the accumulator being read |
| rd_lo_o | output | 32 | LO of the accumulator being read |
| fault_o | output | 1 | Disabled-request fault pulse |

## Verification
An accumulator update lands on the same edge that samples `valid_i`. The bench drives each request at a falling edge and lets one rising edge pass. At the next falling edge it drops `valid_i` and steps `rd_sel_i` through all four indices, with a short delay after each step, to compare every pair against its model. `fault_o` is registered, so it is checked at that same falling edge. It is checked again one cycle later to confirm that the pulse has ended.

// File: rtl/mac_pkg.sv
package mac_pkg;
    localparam int DATA_W = 32;
    localparam int N_ACC  = 4;
    localparam int ACC_W  = 2 * DATA_W;
    localparam int SEL_W  = $clog2(N_ACC);

    typedef enum logic [1:0] {
        OP_MADDU = 2'd0,
        OP_MULTU = 2'd1,
        OP_MSUB  = 2'd2,
        OP_MSUBU = 2'd3
    } mac_op_e;

    typedef struct packed {
        logic fault;
    } ctrl_t;
endpackage

// File: rtl/mac_product.sv
module mac_product #(
    parameter int W = mac_pkg::DATA_W
) (
    input  logic           signed_i,
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    output logic [2*W-1:0] prod_o
);
    logic [2*W-1:0] a_ext;
    logic [2*W-1:0] b_ext;

    always_comb begin
        a_ext  = signed_i ? {{W{a_i[W-1]}}, a_i} : {{W{1'b0}}, a_i};
        b_ext  = signed_i ? {{W{b_i[W-1]}}, b_i} : {{W{1'b0}}, b_i};
        prod_o = a_ext * b_ext;
    end
endmodule

// File: rtl/mac_combine.sv
module mac_combine
    import mac_pkg::*;
#(
    parameter int W2 = ACC_W
) (
    input  mac_op_e         op_i,
    input  logic [W2-1:0]   old_i,
    input  logic [W2-1:0]   prod_i,
    output logic [W2-1:0]   new_o
);
    always_comb begin
        unique case (op_i)
            OP_MADDU: new_o = old_i + prod_i;
            OP_MULTU: new_o = prod_i;
            OP_MSUB,
            OP_MSUBU: new_o = old_i - prod_i;
            default:  new_o = old_i;
        endcase
    end
endmodule

// File: rtl/mac_acc_bank.sv
module mac_acc_bank #(
    parameter int N     = mac_pkg::N_ACC,
    parameter int W2    = mac_pkg::ACC_W,
    localparam int SW   = $clog2(N)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we_i,
    input  logic [SW-1:0]        wsel_i,
    input  logic [W2-1:0]        wdata_i,
    input  logic [SW-1:0]        rsel_i,
    output logic [W2-1:0]        rdata_o,
    output logic [N-1:0][W2-1:0] acc_all_o
);
    logic [N-1:0][W2-1:0] acc_d;
    logic [N-1:0][W2-1:0] acc_q;

    always_comb begin
        acc_d = acc_q;
        if (rst) begin
            acc_d = '0;
        end else if (we_i) begin
            acc_d[wsel_i] = wdata_i;
        end
    end

    always_ff @(posedge clk) begin
        acc_q <= acc_d;
    end

    assign rdata_o   = acc_q[rsel_i];
    assign acc_all_o = acc_q;

    assert_reset_clear_R9: assert property (@(posedge clk)
        rst |=> (acc_q == '0));

    for (genvar g = 0; g < N; g++) begin : g_hold
        assert_unselected_hold_R10: assert property (@(posedge clk) disable iff (rst)
            !(we_i && (wsel_i == SW'(g))) |=> $stable(acc_q[g]));
    end
endmodule

// File: rtl/mac_quad_acc.sv
module mac_quad_acc
    import mac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              valid_i,
    input  logic              dsp_en_i,
    input  logic [1:0]        op_i,
    input  logic [31:0]       instr_i,
    input  logic [DATA_W-1:0] opa_i,
    input  logic [DATA_W-1:0] opb_i,
    input  logic [SEL_W-1:0]  rd_sel_i,
    output logic [DATA_W-1:0] rd_hi_o,
    output logic [DATA_W-1:0] rd_lo_o,
    output logic              fault_o
);
    localparam int FIELD_LO = 14;

    mac_op_e                    op;
    logic [SEL_W-1:0]           acc_sel;
    logic                       issue;
    logic [ACC_W-1:0]           prod;
    logic [ACC_W-1:0]           old_val;
    logic [ACC_W-1:0]           new_val;
    logic [ACC_W-1:0]           rdata;
    logic [N_ACC-1:0][ACC_W-1:0] acc_all;
    ctrl_t                      ctrl_d;
    ctrl_t                      ctrl_q;
    logic                       unused_instr;

    assign op           = mac_op_e'(op_i);
    assign acc_sel      = instr_i[FIELD_LO +: SEL_W];
    assign unused_instr = ^{instr_i[31:FIELD_LO+SEL_W], instr_i[FIELD_LO-1:0]};
    assign issue        = valid_i && dsp_en_i;
    assign old_val      = acc_all[acc_sel];

    mac_product #(.W(DATA_W)) i_product (
        .signed_i (op == OP_MSUB),
        .a_i      (opa_i),
        .b_i      (opb_i),
        .prod_o   (prod)
    );

    mac_combine #(.W2(ACC_W)) i_combine (
        .op_i   (op),
        .old_i  (old_val),
        .prod_i (prod),
        .new_o  (new_val)
    );

    mac_acc_bank #(.N(N_ACC), .W2(ACC_W)) i_bank (
        .clk       (clk),
        .rst       (rst),
        .we_i      (issue),
        .wsel_i    (acc_sel),
        .wdata_i   (new_val),
        .rsel_i    (rd_sel_i),
        .rdata_o   (rdata),
        .acc_all_o (acc_all)
    );

    always_comb begin
        ctrl_d = ctrl_q;
        if (rst) begin
            ctrl_d.fault = 1'b0;
        end else begin
            ctrl_d.fault = valid_i && !dsp_en_i;
        end
    end

    always_ff @(posedge clk) begin
        ctrl_q <= ctrl_d;
    end

    assign rd_hi_o = rdata[ACC_W-1:DATA_W];
    assign rd_lo_o = rdata[DATA_W-1:0];
    assign fault_o = ctrl_q.fault;

    assert_fault_raise_R8: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !dsp_en_i) |=> fault_o);

    assert_fault_quiet_R8: assert property (@(posedge clk) disable iff (rst)
        !(valid_i && !dsp_en_i) |=> !fault_o);

    assert_disabled_no_write_R7: assert property (@(posedge clk) disable iff (rst)
        (valid_i && !dsp_en_i) |=> $stable(acc_all));

    assert_multu_overwrite_R3: assert property (@(posedge clk) disable iff (rst)
        (issue && op == OP_MULTU) |=>
        acc_all[$past(acc_sel)] == ({32'd0, $past(opa_i)} * {32'd0, $past(opb_i)}));

    assert_maddu_sum_R2: assert property (@(posedge clk) disable iff (rst)
        (issue && op == OP_MADDU) |=>
        acc_all[$past(acc_sel)] == ($past(old_val) + ({32'd0, $past(opa_i)} * {32'd0, $past(opb_i)})));
endmodule

// File: tb/test_mac_quad_acc.sv
module test_mac_quad_acc;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        valid_i = 1'b0;
    logic        dsp_en_i = 1'b1;
    logic [1:0]  op_i = 2'd0;
    logic [31:0] instr_i = 32'd0;
    logic [31:0] opa_i = 32'd0;
    logic [31:0] opb_i = 32'd0;
    logic [1:0]  rd_sel_i = 2'd0;
    logic [31:0] rd_hi_o;
    logic [31:0] rd_lo_o;
    logic        fault_o;

    int errors = 0;
    int checks = 0;
    logic [63:0] model [4];

    always #(CLK_PERIOD/2) clk = ~clk;

    mac_quad_acc i_mac_quad_acc (
        .clk(clk), .rst(rst), .valid_i(valid_i), .dsp_en_i(dsp_en_i),
        .op_i(op_i), .instr_i(instr_i), .opa_i(opa_i), .opb_i(opb_i),
        .rd_sel_i(rd_sel_i), .rd_hi_o(rd_hi_o), .rd_lo_o(rd_lo_o),
        .fault_o(fault_o)
    );

    function automatic logic [63:0] ref_next(input logic [1:0] op, input logic [63:0] old,
                                             input logic [31:0] a, input logic [31:0] b);
        logic [63:0] pu;
        logic [63:0] ps;
        pu = {32'd0, a} * {32'd0, b};
        ps = {{32{a[31]}}, a} * {{32{b[31]}}, b};
        case (op)
            2'd0:    return old + pu;
            2'd1:    return pu;
            2'd2:    return old - ps;
            default: return old - pu;
        endcase
    endfunction

    task automatic check64(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int k = 0; k < 4; k++) begin
            rd_sel_i = 2'(k);
            #1;
            check64(req, {rd_hi_o, rd_lo_o}, model[k]);
        end
    endtask

    task automatic do_op(input string req, input logic v, input logic en, input logic [1:0] op,
                         input logic [1:0] sel, input logic [31:0] a, input logic [31:0] b);
        logic [31:0] junk;
        junk = $urandom;
        @(negedge clk);
        valid_i  = v;
        dsp_en_i = en;
        op_i     = op;
        instr_i  = {junk[31:16], sel, junk[13:0]};
        opa_i    = a;
        opb_i    = b;
        @(posedge clk);
        if (v && en) model[sel] = ref_next(op, model[sel], a, b);
        @(negedge clk);
        valid_i = 1'b0;
        check64({req, " fault"}, {63'd0, fault_o}, {63'd0, v && !en});
        check_all(req);
    endtask

    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        for (int k = 0; k < 4; k++) model[k] = 64'd0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R9 reset state
        check64("R9 fault", {63'd0, fault_o}, 64'd0);
        check_all("R9");

        // R3 largest unsigned product, R11 readback
        do_op("R3", 1, 1, 2'd1, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        check64("R3 value", model[2], 64'hFFFF_FFFE_0000_0001);
        // R4 signed: 0 - (-1 * 1) = 1
        do_op("R4", 1, 1, 2'd2, 2'd1, 32'hFFFF_FFFF, 32'd1);
        check64("R4 value", model[1], 64'd1);
        // R5/R6 unsigned subtract wraps below zero
        do_op("R5", 1, 1, 2'd3, 2'd0, 32'd1, 32'd1);
        check64("R6 wrap", model[0], 64'hFFFF_FFFF_FFFF_FFFF);
        // R2/R6 add wraps past top
        do_op("R2", 1, 1, 2'd0, 2'd0, 32'd1, 32'd1);
        check64("R6 wrap add", model[0], 64'd0);
        // R1 each index selects its own pair
        for (int k = 0; k < 4; k++) do_op("R1", 1, 1, 2'd1, 2'(k), 32'(k + 3), 32'h1000_0001);
        // R7/R8 disabled request: no change, fault pulse
        do_op("R7", 1, 0, 2'd1, 2'd3, 32'h1234_5678, 32'h9ABC_DEF0);
        do_op("R8", 0, 1, 2'd1, 2'd3, 32'h1, 32'h1);
        check64("R8 pulse ended", {63'd0, fault_o}, 64'd0);
        // R10 valid low changes nothing
        do_op("R10", 0, 1, 2'd0, 2'd2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        // R4 signed with mixed signs on a nonzero accumulator
        do_op("R4", 1, 1, 2'd2, 2'd3, 32'h8000_0000, 32'h7FFF_FFFF);

        // random mix
        for (int n = 0; n < 300; n++) begin
            logic [31:0] r;
            r = $urandom;
            do_op("R2 R3 R4 R5 R10 random", r[4:0] != 5'd0, r[9:5] != 5'd0, r[11:10], r[13:12],
                  $urandom, $urandom);
        end

        // R9 reset mid-run clears everything
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        for (int k = 0; k < 4; k++) model[k] = 64'd0;
        check64("R9 fault after reset", {63'd0, fault_o}, 64'd0);
        check_all("R9 mid-run");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule